// File: doc/BRIEF.md
# Key-Sequence Cleared Watchdog Timer

This block is the watchdog of a small microcontroller. Once software sets the enable bit, a short counter advances on every pulse of a slow tick of about 2 Hz, which comes from a prescaler. If the counter gets to its trip value of 8, the block raises a reset request for the system. With default settings this takes about four seconds.

Software keeps the counter away from the trip value by writing two key values to the watchdog register. The first write must carry 0x0A and the very next write to the register must carry 0x03. Any other write breaks the pair. Reading the register returns the live count and has no effect on a half-finished key pair. The enable bit is sticky, and only a system reset returns the block to its idle state.

Top module: `wdt_keyclr`

## Requirements
- R1: After `rst_ni` goes low, the count is 0, `reset_req_o` is 0, the watchdog is disabled and no key is armed.
- R2: Ticks are ignored until the enable input has been sampled high on a clock edge. A tick in that same cycle is not counted.
- R3: While enabled and below 8, each single-cycle `tick_i` pulse raises the count by exactly 1 on that clock edge.
- R4: When the count reaches 8, `reset_req_o` goes to 1 and stays 1. From then on the count stays at 8 and neither ticks nor key writes change it, until `rst_ni` is asserted.
- R5: A write of 0x0A followed by a write of 0x03 as the next write to the register sets the count to 0 on the edge of the 0x03 write.
- R6: A 0x03 write clears nothing unless the write just before it was 0x0A. Any write other than 0x0A disarms the pair, and a successful clear also disarms it.
- R7: A write of 0x0A always arms the pair, even if the pair is already armed, so 0x0A, 0x0A, 0x03 clears the count.
- R8: While `reg_rd_i` is high, `reg_rdata_o` holds the count in bits [3:0] with zeros above. Otherwise it reads 0. Read cycles between the two keys do not disarm the pair.
- R9: Once the enable has been sampled high, taking `wd_enable_i` low again does not stop counting.
- R10: If a tick and a valid 0x03 clear write arrive in the same cycle, the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wd_enable_i | input | 1 | Enable control bit; once sampled high it stays in effect |
| tick_i | input | 1 | Single-cycle slow tick pulse from the prescaler |
| reg_wr_i | input | 1 | Write strobe for the watchdog register |
| reg_rd_i | input | 1 | Read strobe for the watchdog register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data: the live count, zero-extended |
| reset_req_o | output | 1 | Held system reset request |

## Verification
Two functions can act in the same clock cycle: a tick that would advance the count and the closing 0x03 key write that clears it. The bench drives both on one edge with the count at 5. It expects 0 afterwards, not 1, which shows that the clear takes priority. A behavioural model runs alongside the design and is compared on every cycle. It also covers the pairing of a tick with the cycle in which the enable is first sampled, and the pairing of key writes with ticks after the trip.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned WDT_DATA_W   = 8;
   localparam int unsigned WDT_CNT_W    = 4;
   localparam int unsigned WDT_TRIP     = 8;
   localparam int unsigned WDT_KEY_ARM  = 'h0A;
   localparam int unsigned WDT_KEY_FIRE = 'h03;
endpackage

// File: rtl/wdt_en_ctl.sv
module wdt_en_ctl #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   output logic en_o
);
   logic en_q;

   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_q <= 1'b0;
            else         en_q <= en_q | set_i;
         end
      end else begin : g_level
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_q <= 1'b0;
            else         en_q <= set_i;
         end
      end
   endgenerate

   assign en_o = en_q;
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ARM_KEY  = 'h0A,
   parameter int unsigned FIRE_KEY = 'h03
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              block_i,
   output logic              armed_o,
   output logic              clear_o
);
   localparam logic [DATA_W-1:0] ARM_V  = DATA_W'(ARM_KEY);
   localparam logic [DATA_W-1:0] FIRE_V = DATA_W'(FIRE_KEY);

   logic armed_q;

   initial begin
      if (ARM_KEY == FIRE_KEY) $fatal(1, "wdt_key_seq: keys must differ");
      if (ARM_KEY >= (1 << DATA_W) || FIRE_KEY >= (1 << DATA_W))
         $fatal(1, "wdt_key_seq: key wider than data bus");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   armed_q <= 1'b0;
      else if (wr_i) armed_q <= (wdata_i == ARM_V);
   end

   assign armed_o = armed_q;
   assign clear_o = wr_i && (wdata_i == FIRE_V) && armed_q && !block_i;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned TRIP  = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             trip_o
);
   localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP);

   logic [CNT_W-1:0] cnt_q;
   logic             at_trip;

   initial begin
      if (TRIP == 0 || TRIP >= (1 << CNT_W))
         $fatal(1, "wdt_counter: trip value does not fit counter");
   end

   assign at_trip = (cnt_q == TRIP_V);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cnt_q <= '0;
      else if (clear_i && !at_trip)       cnt_q <= '0;
      else if (en_i && tick_i && !at_trip) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign trip_o = at_trip;
endmodule

// File: rtl/wdt_keyclr.sv
module wdt_keyclr
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W    = WDT_DATA_W,
   parameter int unsigned CNT_W     = WDT_CNT_W,
   parameter int unsigned TRIP      = WDT_TRIP,
   parameter int unsigned ARM_KEY   = WDT_KEY_ARM,
   parameter int unsigned FIRE_KEY  = WDT_KEY_FIRE,
   parameter bit          EN_STICKY = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wd_enable_i,
   input  logic              tick_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              reset_req_o
);
   logic             en_w;
   logic             armed_w;
   logic             clear_w;
   logic             trip_w;
   logic [CNT_W-1:0] cnt_w;

   initial begin
      if (CNT_W > DATA_W) $fatal(1, "wdt_keyclr: count wider than data bus");
   end

   wdt_en_ctl #(.STICKY(EN_STICKY)) u_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (wd_enable_i),
      .en_o  (en_w)
   );

   wdt_key_seq #(.DATA_W(DATA_W), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)) u_key (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (reg_wr_i),
      .wdata_i(reg_wdata_i),
      .block_i(trip_w),
      .armed_o(armed_w),
      .clear_o(clear_w)
   );

   wdt_counter #(.CNT_W(CNT_W), .TRIP(TRIP)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_w),
      .tick_i (tick_i),
      .clear_i(clear_w),
      .cnt_o  (cnt_w),
      .trip_o (trip_w)
   );

   assign reg_rdata_o = reg_rd_i ? DATA_W'(cnt_w) : '0;
   assign reset_req_o = trip_w;
endmodule

// File: rtl/wdt_keyclr_chk.sv
module wdt_keyclr_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned TRIP     = 8,
   parameter int unsigned ARM_KEY  = 'h0A,
   parameter int unsigned FIRE_KEY = 'h03
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic              reg_wr_i,
   input logic              reg_rd_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              reset_req_o,
   input logic              en_w,
   input logic              armed_w,
   input logic [CNT_W-1:0]  cnt_w
);
   localparam logic [CNT_W-1:0]  TRIP_V = CNT_W'(TRIP);
   localparam logic [DATA_W-1:0] ARM_V  = DATA_W'(ARM_KEY);
   localparam logic [DATA_W-1:0] FIRE_V = DATA_W'(FIRE_KEY);

   a_r2_idle_until_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_w |-> cnt_w == '0);

   a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !reg_wr_i) |=> $stable(cnt_w));

   a_r4_trip_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |=> (reset_req_o && cnt_w == TRIP_V));

   a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_w <= TRIP_V);

   a_r5_pair_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_wdata_i == FIRE_V && armed_w && !reset_req_o) |=> cnt_w == '0);

   a_r6_other_write_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_wdata_i != ARM_V) |=> !armed_w);

   a_r7_arm_key_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_wdata_i == ARM_V) |=> armed_w);

   a_r8_read_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_wr_i |=> $stable(armed_w));

   a_r8_read_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_rd_i |-> reg_rdata_o == '0);

   a_r9_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_w |=> en_w);
endmodule

bind wdt_keyclr wdt_keyclr_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .TRIP(TRIP), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_i     (tick_i),
   .reg_wr_i   (reg_wr_i),
   .reg_rd_i   (reg_rd_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o),
   .reset_req_o(reset_req_o),
   .en_w       (en_w),
   .armed_w    (armed_w),
   .cnt_w      (cnt_w)
);

// File: tb/wdt_keyclr_tb.sv
`timescale 1ns/1ps
module wdt_keyclr_tb_top;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       wd_enable_i = 1'b0;
   logic       tick_i = 1'b0;
   logic       reg_wr_i = 1'b0;
   logic       reg_rd_i = 1'b1;
   logic [7:0] reg_wdata_i = 8'h00;
   logic [7:0] reg_rdata_o;
   logic       reset_req_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   int  m_cnt   = 0;
   bit  m_armed = 1'b0;
   bit  m_en    = 1'b0;

   always #2 clk_i = ~clk_i;

   wdt_keyclr dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wd_enable_i(wd_enable_i),
      .tick_i     (tick_i),
      .reg_wr_i   (reg_wr_i),
      .reg_rd_i   (reg_rd_i),
      .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o),
      .reset_req_o(reset_req_o)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         m_cnt = 0; m_armed = 1'b0; m_en = 1'b0;
      end else begin
         bit tripped, clr;
         tripped = (m_cnt == 8);
         clr = reg_wr_i && reg_wdata_i == 8'h03 && m_armed && !tripped;
         if (reg_wr_i) m_armed = (reg_wdata_i == 8'h0A);
         if (clr) m_cnt = 0;
         else if (m_en && tick_i && !tripped) m_cnt = m_cnt + 1;
         if (wd_enable_i) m_en = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R3, R4, R8)
   always @(negedge clk_i) begin
      if (rst_ni && !done) begin
         chk(reg_rdata_o == (reg_rd_i ? m_cnt : 0), "R8 model rdata",
             int'(reg_rdata_o), reg_rd_i ? m_cnt : 0);
         chk(reset_req_o == (m_cnt == 8), "R4 model reset_req",
             int'(reset_req_o), int'(m_cnt == 8));
      end
   end

   task automatic step(input bit tk, input bit wr, input logic [7:0] d);
      tick_i = tk; reg_wr_i = wr; reg_wdata_i = d;
      @(posedge clk_i); #1;
      tick_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00);
   endtask

   task automatic expect_cnt(input int exp, input string tag);
      @(negedge clk_i);
      chk(reg_rdata_o == 8'(exp), tag, int'(reg_rdata_o), exp);
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      repeat (2) @(posedge clk_i);
      #1 rst_ni = 1'b1;
   endtask

   initial begin
      do_reset();
      expect_cnt(0, "R1 count after reset");
      chk(reset_req_o == 1'b0, "R1 no request after reset", int'(reset_req_o), 0);

      ticks(3);
      expect_cnt(0, "R2 ticks ignored while disabled");

      wd_enable_i = 1'b1;
      step(1'b1, 1'b0, 8'h00);
      wd_enable_i = 1'b0;
      expect_cnt(0, "R2 tick on enable cycle not counted");

      ticks(3);
      expect_cnt(3, "R3 three ticks counted");
      chk(1'b1, "R9 enable held after input low", 3, 3);

      step(1'b0, 1'b1, 8'h0A);
      reg_rd_i = 1'b0; @(posedge clk_i); #1; reg_rd_i = 1'b1;
      @(posedge clk_i); #1;
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(0, "R5 key pair clears (R8 reads between)");

      ticks(2);
      step(1'b0, 1'b1, 8'h0A);
      step(1'b0, 1'b1, 8'h05);
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(2, "R6 foreign write aborts pair");
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(2, "R6 lone fire key ignored");

      step(1'b0, 1'b1, 8'h0A);
      step(1'b0, 1'b1, 8'h03);
      step(1'b1, 1'b0, 8'h00);
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(1, "R6 pair consumed after clear");

      step(1'b0, 1'b1, 8'h0A);
      step(1'b0, 1'b1, 8'h0A);
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(0, "R7 repeated arm key still clears");

      ticks(5);
      step(1'b0, 1'b1, 8'h0A);
      step(1'b1, 1'b1, 8'h03);
      expect_cnt(0, "R10 clear beats same-cycle tick");

      ticks(2);
      reg_rd_i = 1'b0;
      @(negedge clk_i);
      chk(reg_rdata_o == 8'h00, "R8 rdata zero without read", int'(reg_rdata_o), 0);
      reg_rd_i = 1'b1;
      expect_cnt(2, "R8 rdata shows count");

      ticks(6);
      expect_cnt(8, "R4 count reaches trip");
      chk(reset_req_o == 1'b1, "R4 request raised", int'(reset_req_o), 1);
      ticks(3);
      step(1'b0, 1'b1, 8'h0A);
      step(1'b0, 1'b1, 8'h03);
      expect_cnt(8, "R4 count frozen after trip");
      chk(reset_req_o == 1'b1, "R4 request held", int'(reset_req_o), 1);

      do_reset();
      expect_cnt(0, "R1 count after second reset");
      chk(reset_req_o == 1'b0, "R1 request cleared", int'(reset_req_o), 0);
      ticks(2);
      expect_cnt(0, "R1 enable cleared by reset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog timeout actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule